// File: doc/BRIEF.md
# Sense-Reversing Barrier Unit

This block synchronizes a fixed group of participants at a barrier. Before each barrier episode a participant flips its own sense bit. It then announces its arrival with a one-cycle pulse on its arrive line, carrying the flipped sense on the matching bit of the sense bus. The unit counts arrivals in one shared counter. Any number of participants may arrive in the same cycle, and they are all added in that cycle.

When the count reaches the group size, the unit clears the counter and inverts the shared flag. The flag then equals the sense that every participant carried in that episode. A participant's release output is high whenever the flag matches the sense the unit last recorded for that participant. An accepted arrival therefore blocks the participant until the episode completes. The sense alternates from one episode to the next, so the barrier can be used again at once with no separate reset phase. A participant that races ahead carries the opposite sense and cannot slip through the next barrier early.

The unit ignores two kinds of arrival and reports each of them on a one-cycle error pulse. The first is a second arrival from the same participant in one episode. The second is an arrival whose sense was not flipped.

Top module: `sr_barrier`

## Requirements
- R1: After reset the flag output is 0, every release bit is 1, the error output is 0 and no arrival is counted.
- R2: An arrival is accepted when its participant has not yet arrived in the current episode and its sense bit equals the inverse of the current flag. An accepted arrival that does not complete the episode drives that participant's release bit to 0 from the next cycle on.
- R3: All arrivals accepted in one cycle are counted together. The episode completes in the cycle where the total of accepted arrivals reaches the participant count, whether they came one per cycle, in groups, or all at once.
- R4: On completion, the flag output inverts in the next cycle, the count returns to zero and every participant becomes eligible to arrive again. Without a completion the flag holds its value.
- R5: In the cycle after completion every release bit is 1. Each bit stays 1 until its participant's next accepted arrival.
- R6: A second arrival from a participant within one episode is not counted, leaves that participant's state unchanged, and raises the error output for exactly the next cycle.
- R7: An arrival whose sense bit equals the current flag (not flipped) is not counted, does not change the release bit, and raises the error output for exactly the next cycle.
- R8: An arrival in the cycle directly after a completion, carrying the newly reversed sense, is accepted and counted toward the new episode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| arrive_i | input | N_PART | One-cycle arrival pulse, one bit per participant |
| sense_i | input | N_PART | Flipped local sense of each arriving participant, valid with arrive_i |
| release_o | output | N_PART | High while the flag equals the participant's recorded sense |
| flag_o | output | 1 | Global barrier flag |
| err_o | output | 1 | One-cycle pulse after an ignored (duplicate or unflipped) arrival |

## Verification
A fault in the arrival counter shows up at the ports in the cycle after the wrong total reaches the group size. The flag inverts one arrival too early, or not at all, and release_o rises for everyone before the last participant has arrived, or never rises. A fault in the recorded sense or in the arrived marks shows up within one cycle of the next arrival from that participant. Its release bit stays high when it should drop, or a legal arrival raises err_o. The directed scenarios therefore sample release_o, flag_o and err_o after every single arrival cycle, including a duplicate arrival placed right before the real last arrival and an arrival placed directly after a completion.

// File: rtl/sr_barrier_pkg.sv
// Package: shared types for the sense-reversing barrier.
// Assumes: nothing beyond IEEE 1800-2017.
package sr_barrier_pkg;

    // Cause of an ignored arrival in one cycle
    typedef struct packed {
        logic dup;        // participant already arrived this episode
        logic stale;      // sense bit not flipped relative to flag
    } arr_fault_t;

endpackage

// File: rtl/sr_arrival_filter.sv
// Module: per-participant arrival filter and sense tracker.
// It accepts an arrival only when the participant has not arrived in the
// current episode and carries the inverse of the flag. It records the
// carried sense and marks the participant as arrived.
// Assumes: clear_i is high in the cycle the episode completes. Arrivals
// accepted in that same cycle belong to the completing episode.
module sr_arrival_filter
    import sr_barrier_pkg::*;
#(
    parameter int N_PART = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PART-1:0] arrive_i,
    input  logic [N_PART-1:0] sense_i,
    input  logic              flag_i,
    input  logic              clear_i,
    output logic [N_PART-1:0] accept_o,
    output logic [N_PART-1:0] sense_q_o,
    output arr_fault_t        fault_o
);

    logic [N_PART-1:0] arrived_q;
    logic [N_PART-1:0] sense_q;
    logic [N_PART-1:0] dup_vec;
    logic [N_PART-1:0] stale_vec;

    genvar gi;
    generate
        for (gi = 0; gi < N_PART; gi++) begin : g_part
            // Classify this participant's arrival for the current cycle
            always_comb begin
                dup_vec[gi]   = arrive_i[gi] && arrived_q[gi];
                stale_vec[gi] = arrive_i[gi] && !arrived_q[gi] && (sense_i[gi] == flag_i);
                accept_o[gi]  = arrive_i[gi] && !arrived_q[gi] && (sense_i[gi] != flag_i);
            end

            // Track the arrived mark and the recorded sense of this participant
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    arrived_q[gi] <= 1'b0;
                    sense_q[gi]   <= 1'b0;
                end else begin
                    if (clear_i)
                        arrived_q[gi] <= 1'b0;
                    else if (accept_o[gi])
                        arrived_q[gi] <= 1'b1;
                    if (accept_o[gi])
                        sense_q[gi] <= sense_i[gi];
                end
            end

            // A repeated arrival must leave the recorded sense untouched
            AST_DUP_KEEPS_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
                dup_vec[gi] |=> $stable(sense_q[gi])); // R6
        end
    endgenerate

    assign sense_q_o     = sense_q;
    assign fault_o.dup   = |dup_vec;
    assign fault_o.stale = |stale_vec;

endmodule

// File: rtl/sr_arrival_counter.sv
// Module: shared arrival counter with same-cycle accumulation.
// It adds the number of accepted arrivals of each cycle to the running count.
// It flags completion when the total reaches N_PART and then returns to zero.
// Assumes: each participant is accepted at most once per episode, so the
// running count stays below N_PART between completions.
module sr_arrival_counter #(
    parameter int N_PART = 4,
    localparam int CNT_W = $clog2(N_PART + 1),
    localparam int SUM_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PART-1:0] accept_i,
    output logic              last_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pop;
    logic [SUM_W-1:0] total;

    // Population count of the accepted-arrival vector
    always_comb begin
        pop = '0;
        for (int k = 0; k < N_PART; k++)
            pop = pop + CNT_W'(accept_i[k]);
    end

    // Running total after this cycle's arrivals, and the completion test
    always_comb begin
        total  = SUM_W'(cnt_q) + SUM_W'(pop);
        last_o = (total == SUM_W'(N_PART));
    end

    // Hold the count of arrivals in the open episode
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (last_o)
            cnt_q <= '0;
        else
            cnt_q <= total[CNT_W-1:0];
    end

    AST_CNT_BELOW_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(N_PART)); // R3
    AST_CNT_ZERO_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/sr_flag_reg.sv
// Module: global barrier flag.
// It inverts on every completed episode and otherwise holds.
// Assumes: complete_i is high for exactly the completing cycle.
module sr_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic complete_i,
    output logic flag_o
);

    logic flag_q;

    // Invert the flag when an episode completes
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (complete_i)
            flag_q <= !flag_q;
    end

    assign flag_o = flag_q;

    AST_FLAG_FLIPS_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        complete_i |=> (flag_q != $past(flag_q))); // R4
    AST_FLAG_HOLDS_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
        !complete_i |=> $stable(flag_q)); // R4

endmodule

// File: rtl/sr_barrier.sv
// Module: top of the sense-reversing barrier unit.
// It ties together the arrival filter, the shared counter and the flag. It
// derives the per-participant release outputs and the registered error pulse.
// Assumes: arrive_i bits are single-cycle pulses, and sense_i is meaningful
// only where arrive_i is high.
module sr_barrier
    import sr_barrier_pkg::*;
#(
    parameter int N_PART = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PART-1:0] arrive_i,
    input  logic [N_PART-1:0] sense_i,
    output logic [N_PART-1:0] release_o,
    output logic              flag_o,
    output logic              err_o
);

    logic [N_PART-1:0] accept;
    logic [N_PART-1:0] sense_q;
    arr_fault_t        fault;
    logic              last;
    logic              flag;
    logic              err_q;

    sr_arrival_filter #(.N_PART(N_PART)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .arrive_i (arrive_i),
        .sense_i  (sense_i),
        .flag_i   (flag),
        .clear_i  (last),
        .accept_o (accept),
        .sense_q_o(sense_q),
        .fault_o  (fault)
    );

    sr_arrival_counter #(.N_PART(N_PART)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept_i(accept),
        .last_o  (last)
    );

    sr_flag_reg u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .complete_i(last),
        .flag_o    (flag)
    );

    // Register a one-cycle error pulse for any ignored arrival
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= fault.dup || fault.stale;
    end

    // A participant is released while the flag matches its recorded sense
    always_comb begin
        release_o = ~(sense_q ^ {N_PART{flag}});
    end

    assign flag_o = flag;
    assign err_o  = err_q;

    AST_ALL_FREE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (&release_o)); // R5
    AST_DUP_RAISES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        fault.dup |=> err_o); // R6
    AST_STALE_RAISES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        fault.stale |=> err_o); // R7

    genvar gi;
    generate
        for (gi = 0; gi < N_PART; gi++) begin : g_chk
            AST_WAIT_AFTER_ARRIVE: assert property (@(posedge clk) disable iff (!rst_n)
                (accept[gi] && !last) |=> !release_o[gi]); // R2
        end
    endgenerate

endmodule

// File: tb/sr_barrier_test.sv
// Directed bench for sr_barrier with four participants.
// Inputs are driven at the falling edge. Outputs are sampled at the next
// falling edge, after the rising edge that consumed the inputs.
module sr_barrier_test;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] arrive_i = '0;
    logic [NP-1:0] sense_i = '0;
    logic [NP-1:0] release_o;
    logic          flag_o;
    logic          err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    sr_barrier #(.N_PART(NP)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .arrive_i (arrive_i),
        .sense_i  (sense_i),
        .release_o(release_o),
        .flag_o   (flag_o),
        .err_o    (err_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One arrival cycle: drive at the current falling edge, wait one cycle
    task automatic pulse(input logic [NP-1:0] a, input logic [NP-1:0] s);
        arrive_i = a;
        sense_i  = s;
        @(negedge clk);
        arrive_i = '0;
        sense_i  = '0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 release", 32'(release_o), 32'hF);
        check("R1 flag", 32'(flag_o), 0);
        check("R1 err", 32'(err_o), 0);
    endtask

    // One arrival per cycle, flag 0 so the new sense is 1
    task automatic t_serial();
        pulse(4'b0001, 4'b1111);
        check("R2 release after p0", 32'(release_o), 32'b1110);
        check("R2 err", 32'(err_o), 0);
        pulse(4'b0010, 4'b1111);
        check("R2 release after p1", 32'(release_o), 32'b1100);
        pulse(4'b0100, 4'b1111);
        check("R3 release after p2", 32'(release_o), 32'b1000);
        check("R4 flag held", 32'(flag_o), 0);
        pulse(4'b1000, 4'b1111);
        check("R4 flag inverted", 32'(flag_o), 1);
        check("R5 all released", 32'(release_o), 32'hF);
        idle();
        check("R5 release held", 32'(release_o), 32'hF);
    endtask

    // Two groups of two, flag 1 so the new sense is 0
    task automatic t_groups();
        pulse(4'b0011, 4'b0000);
        check("R3 pair counted", 32'(release_o), 32'b1100);
        check("R3 flag held", 32'(flag_o), 1);
        pulse(4'b1100, 4'b0000);
        check("R3 second pair completes", 32'(flag_o), 0);
        check("R5 all released", 32'(release_o), 32'hF);
    endtask

    // Everyone arrives in one cycle, flag 0 so the sense is 1
    task automatic t_all_at_once();
        pulse(4'b1111, 4'b1111);
        check("R3 all-at-once flag", 32'(flag_o), 1);
        check("R3 all-at-once release", 32'(release_o), 32'hF);
        check("R3 no error", 32'(err_o), 0);
    endtask

    // Duplicate arrival from p2 must not be counted; flag 1, sense 0
    task automatic t_duplicate();
        pulse(4'b0100, 4'b0000);
        check("R2 p2 waits", 32'(release_o), 32'b1011);
        pulse(4'b0100, 4'b0000);
        check("R6 err on duplicate", 32'(err_o), 1);
        check("R6 release unchanged", 32'(release_o), 32'b1011);
        idle();
        check("R6 err one cycle", 32'(err_o), 0);
        pulse(4'b0011, 4'b0000);
        check("R6 duplicate not counted flag", 32'(flag_o), 1);
        check("R6 duplicate not counted release", 32'(release_o), 32'b1000);
        pulse(4'b1000, 4'b0000);
        check("R6 real last completes", 32'(flag_o), 0);
        check("R5 released", 32'(release_o), 32'hF);
    endtask

    // Unflipped sense is ignored; flag 0 so sense 0 is stale
    task automatic t_stale();
        pulse(4'b0010, 4'b0000);
        check("R7 err on stale", 32'(err_o), 1);
        check("R7 release unchanged", 32'(release_o), 32'hF);
        idle();
        check("R7 err one cycle", 32'(err_o), 0);
        pulse(4'b1111, 4'b1111);
        check("R7 stale not counted", 32'(flag_o), 1);
        check("R7 no error on legal", 32'(err_o), 0);
    endtask

    // Arrival right after a completion belongs to the new episode
    task automatic t_back_to_back();
        pulse(4'b0111, 4'b0000);
        check("R8 three waiting", 32'(release_o), 32'b1000);
        pulse(4'b1000, 4'b0000);
        check("R8 completion flag", 32'(flag_o), 0);
        pulse(4'b0001, 4'b0001);
        check("R8 immediate arrival accepted", 32'(release_o), 32'b1110);
        check("R8 no error", 32'(err_o), 0);
        check("R8 flag held", 32'(flag_o), 0);
        pulse(4'b1110, 4'b1110);
        check("R8 next episode completes", 32'(flag_o), 1);
        check("R8 all released", 32'(release_o), 32'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_serial();
        t_groups();
        t_all_at_once();
        t_duplicate();
        t_stale();
        t_back_to_back();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule